// File: doc/BRIEF.md
# Four-Channel Alarm Interrupt Register Bank

This block holds the alarm registers of a four-channel line receiver. Each channel delivers two synchronous alarm levels: loss of lock and loss of signal. The block shows the present level of each alarm in a read-only bit. Any change of either alarm, rising or falling, sets a sticky change flag, and a read of that channel's status register clears the flag.

Each channel has a small enable register. An enable bit lets the matching sticky flag pull down one shared active-low interrupt line. Software reaches the registers through a synchronous port with separate read and write strobes, an 8-bit address and 8-bit data. The registers of each channel repeat at a stride of 8 addresses.

Top module: `alarm_irq_bank`

## Requirements
- R1: Synchronous reset (rst high at a clock edge) clears every change flag, every enable bit and rdata to 0, and sets irq_n to 1.
- R2: The enable register of channel n is at address 0x09 + 8*n. Bit 1 enables the loss-of-lock flag and bit 0 enables the loss-of-signal flag. Both are read/write, and its other bits read 0.
- R3: The status register of channel n is at address 0x0A + 8*n. Bit 5 shows lol_in[n] and bit 4 shows los_in[n], each as sampled at the previous clock edge (1 = alarm present).
- R4: A change of lol_in[n] between two consecutive clock edges, in either direction, sets status bit 1. A change of los_in[n] sets status bit 0 in the same way. A level held steady through reset sets neither bit.
- R5: A read of a status register returns the flags as they were before the read, then clears them. A change that arrives at the same clock edge as the read leaves its flag set.
- R6: Bits 7, 6, 3 and 2 of every register read as 0.
- R7: rdata is registered. A read strobe at one edge makes rdata show the addressed register after that edge. A read of an unmapped address gives 0. rdata holds its value while rd_en is low.
- R8: irq_n is registered. After each edge it is 0 exactly when, before that edge, some channel had a change flag set together with its matching enable bit.
- R9: Writes to status registers or to unmapped addresses change no register.
- R10: A change flag whose enable bit is 0 still latches and reads back, but it does not lower irq_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lol_in | input | 4 | Loss-of-lock level per channel, 1 = alarm |
| los_in | input | 4 | Loss-of-signal level per channel, 1 = alarm |
| irq_n | output | 1 | Shared interrupt, active low |

## Verification
The assertions assume that the alarm levels, strobes and address are synchronous to clk and steady at each rising edge. They also assume that rst is high at the first edge, so the change detector has a valid previous sample before any property is checked. The stimulus drives every input on the falling edge and holds rst for several cycles at start. It toggles alarms with a low probability, so that changes, reads and collisions of the two all occur. It picks addresses that are mostly mapped, with the rest drawn from the full 8-bit range.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  // Bit positions decoded by the software driver
  localparam int unsigned BIT_LOL_LIVE = 5;
  localparam int unsigned BIT_LOS_LIVE = 4;
  localparam int unsigned BIT_LOL_CHG  = 1;
  localparam int unsigned BIT_LOS_CHG  = 0;
  localparam int unsigned BIT_LOL_EN   = 1;
  localparam int unsigned BIT_LOS_EN   = 0;

  // Per-channel register offsets from the channel base
  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_STATUS = 1;

  // Number of alarm kinds per channel
  localparam int unsigned N_ALARM = 2;

  typedef struct packed {
    logic lol;
    logic los;
  } alarm_pair_t;
endpackage

// File: rtl/alarm_addr_decode.sv
module alarm_addr_decode #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned EN_BASE = 9,
  parameter int unsigned STRIDE  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] en_hit,
  output logic [NUM_CH-1:0] st_hit
);
  import alarm_irq_pkg::*;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    localparam int unsigned EN_A = EN_BASE + OFS_ENABLE + c * STRIDE;
    localparam int unsigned ST_A = EN_BASE + OFS_STATUS + c * STRIDE;
    assign en_hit[c] = (addr == ADDR_W'(EN_A));
    assign st_hit[c] = (addr == ADDR_W'(ST_A));
  end
endmodule

// File: rtl/alarm_sticky.sv
module alarm_sticky (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  input  logic clr_req,
  output logic live,
  output logic chg_flag
);
  logic prev_q;
  logic change;

  assign change = level_in ^ prev_q;
  assign live   = prev_q;

  // Previous sample follows the input during reset so that a steady
  // level is not taken for a change once reset releases.
  always_ff @(posedge clk) begin
    prev_q <= level_in;
  end

  always_ff @(posedge clk) begin
    if (rst)          chg_flag <= 1'b0;
    else if (change)  chg_flag <= 1'b1;
    else if (clr_req) chg_flag <= 1'b0;
  end
endmodule

// File: rtl/alarm_chan.sv
module alarm_chan (
  input  logic                      clk,
  input  logic                      rst,
  input  alarm_irq_pkg::alarm_pair_t lvl_in,
  input  logic                      en_wr,
  input  logic                      st_rd,
  input  alarm_irq_pkg::alarm_pair_t en_wdata,
  output alarm_irq_pkg::alarm_pair_t live,
  output alarm_irq_pkg::alarm_pair_t chg,
  output alarm_irq_pkg::alarm_pair_t en,
  output alarm_irq_pkg::alarm_pair_t pend
);
  import alarm_irq_pkg::*;

  logic [N_ALARM-1:0] lvl_v, live_v, chg_v;

  assign lvl_v = lvl_in;

  for (genvar k = 0; k < N_ALARM; k++) begin : g_alarm
    alarm_sticky u_sticky (
      .clk      (clk),
      .rst      (rst),
      .level_in (lvl_v[k]),
      .clr_req  (st_rd),
      .live     (live_v[k]),
      .chg_flag (chg_v[k])
    );
  end

  assign live = live_v;
  assign chg  = chg_v;

  always_ff @(posedge clk) begin
    if (rst)        en <= '0;
    else if (en_wr) en <= en_wdata;
  end

  assign pend = chg & en;
endmodule

// File: rtl/alarm_irq_combine.sv
module alarm_irq_combine #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend,
  output logic             irq_n
);
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(|pend);
  end
endmodule

// File: rtl/alarm_irq_bank.sv
module alarm_irq_bank #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned EN_BASE = 9,
  parameter int unsigned STRIDE  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_CH-1:0] lol_in,
  input  logic [NUM_CH-1:0] los_in,
  output logic              irq_n
);
  import alarm_irq_pkg::*;

  localparam int unsigned N_SRC = NUM_CH * N_ALARM;

  logic [NUM_CH-1:0] en_hit, st_hit;
  logic [NUM_CH-1:0] lol_sticky, los_sticky, lol_en, los_en;
  logic [NUM_CH-1:0] lol_live, los_live;
  logic [N_SRC-1:0]  pend_all;
  logic [DATA_W-1:0] rd_word;

  alarm_addr_decode #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .EN_BASE(EN_BASE),
    .STRIDE (STRIDE)
  ) u_dec (
    .addr  (addr),
    .en_hit(en_hit),
    .st_hit(st_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    alarm_pair_t lvl_c, wd_c, live_c, chg_c, en_c, pend_c;

    assign lvl_c.lol = lol_in[c];
    assign lvl_c.los = los_in[c];
    assign wd_c.lol  = wdata[BIT_LOL_EN];
    assign wd_c.los  = wdata[BIT_LOS_EN];

    alarm_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .lvl_in  (lvl_c),
      .en_wr   (wr_en & en_hit[c]),
      .st_rd   (rd_en & st_hit[c]),
      .en_wdata(wd_c),
      .live    (live_c),
      .chg     (chg_c),
      .en      (en_c),
      .pend    (pend_c)
    );

    assign lol_live[c]   = live_c.lol;
    assign los_live[c]   = live_c.los;
    assign lol_sticky[c] = chg_c.lol;
    assign los_sticky[c] = chg_c.los;
    assign lol_en[c]     = en_c.lol;
    assign los_en[c]     = en_c.los;
    assign pend_all[N_ALARM*c +: N_ALARM] = pend_c;
  end

  // Read mux: at most one hit is active, so OR-merge the sources
  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (en_hit[c]) begin
        rd_word[BIT_LOL_EN] = rd_word[BIT_LOL_EN] | lol_en[c];
        rd_word[BIT_LOS_EN] = rd_word[BIT_LOS_EN] | los_en[c];
      end
      if (st_hit[c]) begin
        rd_word[BIT_LOL_LIVE] = rd_word[BIT_LOL_LIVE] | lol_live[c];
        rd_word[BIT_LOS_LIVE] = rd_word[BIT_LOS_LIVE] | los_live[c];
        rd_word[BIT_LOL_CHG]  = rd_word[BIT_LOL_CHG]  | lol_sticky[c];
        rd_word[BIT_LOS_CHG]  = rd_word[BIT_LOS_CHG]  | los_sticky[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  alarm_irq_combine #(
    .N_SRC(N_SRC)
  ) u_irq (
    .clk  (clk),
    .rst  (rst),
    .pend (pend_all),
    .irq_n(irq_n)
  );
endmodule

// File: rtl/alarm_irq_bank_chk.sv
module alarm_irq_bank_chk #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned EN_BASE = 9,
  parameter int unsigned STRIDE  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_n,
  input logic [NUM_CH-1:0] lol_in,
  input logic [NUM_CH-1:0] los_in,
  input logic [NUM_CH-1:0] lol_sticky,
  input logic [NUM_CH-1:0] los_sticky,
  input logic [NUM_CH-1:0] lol_en,
  input logic [NUM_CH-1:0] los_en
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam int unsigned ST_A = EN_BASE + 1 + g * STRIDE;

    AST_LOL_CHANGE_SETS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && lol_in[g] != $past(lol_in[g])) |=> lol_sticky[g]); // R4
    AST_LOS_CHANGE_SETS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && los_in[g] != $past(los_in[g])) |=> los_sticky[g]); // R4
    AST_LOL_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && rd_en && addr == ADDR_W'(ST_A) && lol_in[g] == $past(lol_in[g]))
        |=> !lol_sticky[g]); // R5
    AST_LOS_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && rd_en && addr == ADDR_W'(ST_A) && los_in[g] == $past(los_in[g]))
        |=> !los_sticky[g]); // R5
  end

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata & DATA_W'(8'hCC)) == '0); // R6
  AST_IRQ_FOLLOWS_PENDING: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_n == !$past(|((lol_sticky & lol_en) | (los_sticky & los_en))))); // R8
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rdata)); // R7
endmodule

bind alarm_irq_bank alarm_irq_bank_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .EN_BASE(EN_BASE),
  .STRIDE (STRIDE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .addr      (addr),
  .rdata     (rdata),
  .irq_n     (irq_n),
  .lol_in    (lol_in),
  .los_in    (los_in),
  .lol_sticky(lol_sticky),
  .los_sticky(los_sticky),
  .lol_en    (lol_en),
  .los_en    (los_en)
);

// File: tb/sim_alarm_irq_bank.sv
module sim_alarm_irq_bank;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [3:0] lol_in = '0, los_in = '0;
  logic       irq_n;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // Reference model state
  logic [3:0] m_pl = '0, m_ps = '0, m_sl = '0, m_ss = '0, m_el = '0, m_es = '0;
  logic [7:0] exp_rd = '0;
  logic       exp_irq = 1'b1;

  always #5 clk = ~clk;

  alarm_irq_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lol_in(lol_in), .los_in(los_in), .irq_n(irq_n)
  );

  function automatic logic [7:0] en_addr(int c);
    return 8'(9 + 8 * c);
  endfunction
  function automatic logic [7:0] st_addr(int c);
    return 8'(10 + 8 * c);
  endfunction

  function automatic logic [7:0] model_read(logic [7:0] a);
    logic [7:0] r = '0;
    for (int c = 0; c < 4; c++) begin
      if (a == en_addr(c)) r = {6'b0, m_el[c], m_es[c]};
      if (a == st_addr(c)) r = {2'b0, m_pl[c], m_ps[c], 2'b0, m_sl[c], m_ss[c]};
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock cycle with the model updated from the requirements
  task automatic step(bit rd, bit wr, logic [7:0] a, logic [7:0] wd,
                      logic [3:0] lol, logic [3:0] los);
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd; lol_in = lol; los_in = los;
    @(posedge clk);
    exp_irq = !(|((m_sl & m_el) | (m_ss & m_es)));
    if (rd) exp_rd = model_read(a);
    for (int c = 0; c < 4; c++) begin
      if (lol[c] != m_pl[c]) m_sl[c] = 1'b1;
      else if (rd && a == st_addr(c)) m_sl[c] = 1'b0;
      if (los[c] != m_ps[c]) m_ss[c] = 1'b1;
      else if (rd && a == st_addr(c)) m_ss[c] = 1'b0;
      if (wr && a == en_addr(c)) begin
        m_el[c] = wd[1];
        m_es[c] = wd[0];
      end
    end
    m_pl = lol; m_ps = los;
    #1;
    check(rdata === exp_rd, "R7 read data (R2 R3 R9)", rdata, exp_rd);
    check((rdata & 8'hCC) == 8'h00, "R6 unused bits", rdata & 8'hCC, 8'h00);
    check(irq_n === exp_irq, "R8 irq_n", {7'b0, irq_n}, {7'b0, exp_irq});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 8'h00, lol_in, los_in);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    check(rdata === 8'h00, "R1 rdata after reset", rdata, 8'h00);
    check(irq_n === 1'b1, "R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    step(1, 0, st_addr(0), 8'h00, 4'h0, 4'h0);
    check(rdata === 8'h00, "R1 status after reset", rdata, 8'h00);
    step(1, 0, en_addr(3), 8'h00, 4'h0, 4'h0);
    check(rdata === 8'h00, "R1 enable after reset", rdata, 8'h00);

    // R2: enable read/write, other bits read 0
    step(0, 1, en_addr(2), 8'hFF, 4'h0, 4'h0);
    step(1, 0, en_addr(2), 8'h00, 4'h0, 4'h0);
    check(rdata === 8'h03, "R2 enable readback", rdata, 8'h03);
    step(0, 1, en_addr(2), 8'h00, 4'h0, 4'h0);

    // R3 R4: rising loss of lock on channel 1
    step(0, 0, 8'h00, 8'h00, 4'h2, 4'h0);
    step(1, 0, st_addr(1), 8'h00, 4'h2, 4'h0);
    check(rdata === 8'h22, "R4 rise sets flag, R3 live", rdata, 8'h22);
    step(1, 0, st_addr(1), 8'h00, 4'h2, 4'h0);
    check(rdata === 8'h20, "R5 flag cleared by read", rdata, 8'h20);
    step(0, 0, 8'h00, 8'h00, 4'h0, 4'h0);
    step(1, 0, st_addr(1), 8'h00, 4'h0, 4'h0);
    check(rdata === 8'h02, "R4 fall sets flag", rdata, 8'h02);

    // R5: change coinciding with the read keeps the flag
    step(1, 0, st_addr(3), 8'h00, 4'h0, 4'h8);
    check(rdata === 8'h00, "R5 read before change", rdata, 8'h00);
    step(1, 0, st_addr(3), 8'h00, 4'h0, 4'h8);
    check(rdata === 8'h11, "R5 collision keeps flag", rdata, 8'h11);

    // R9: writes to status and unmapped addresses ignored
    step(0, 0, 8'h00, 8'h00, 4'h0, 4'h0);
    step(0, 1, st_addr(3), 8'hFF, 4'h0, 4'h0);
    step(0, 1, 8'h0B, 8'hFF, 4'h0, 4'h0);
    step(1, 0, st_addr(3), 8'h00, 4'h0, 4'h0);
    check(rdata === 8'h01, "R9 status write ignored", rdata, 8'h01);
    step(1, 0, en_addr(0), 8'h00, 4'h0, 4'h0);
    check(rdata === 8'h00, "R9 enable untouched", rdata, 8'h00);
    step(1, 0, 8'h0B, 8'h00, 4'h0, 4'h0);
    check(rdata === 8'h00, "R7 unmapped reads 0", rdata, 8'h00);

    // R10: disabled flag latches but keeps irq_n high
    step(0, 0, 8'h00, 8'h00, 4'h1, 4'h0);
    idle(2);
    check(irq_n === 1'b1, "R10 disabled flag no irq", {7'b0, irq_n}, 8'h01);
    step(0, 1, en_addr(0), 8'h02, 4'h1, 4'h0);
    idle(2);
    check(irq_n === 1'b0, "R8 enabled flag lowers irq", {7'b0, irq_n}, 8'h00);
    step(1, 0, st_addr(0), 8'h00, 4'h1, 4'h0);
    check(rdata === 8'h22, "R10 flag readable", rdata, 8'h22);
    idle(2);
    check(irq_n === 1'b1, "R8 irq released after clear", {7'b0, irq_n}, 8'h01);

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [3:0] l, s;
      int c = int'($urandom % 4);
      case ($urandom % 5)
        0:       a = en_addr(c);
        1, 2:    a = st_addr(c);
        3:       a = 8'($urandom);
        default: a = 8'(9 + 8 * c + ($urandom % 8));
      endcase
      l = lol_in; s = los_in;
      if ($urandom % 8 == 0) l[$urandom % 4] = ~l[$urandom % 4];
      if ($urandom % 8 == 0) s[$urandom % 4] = ~s[$urandom % 4];
      step(($urandom % 2) == 1, ($urandom % 4) == 0, a, 8'($urandom), l, s);
    end

    finish_run();
  end
endmodule